// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address for a processor running in real mode. It keeps six 16-bit segment registers: code, stack, data, extra and two auxiliary segments. Each register holds the upper sixteen bits of a segment base. Four zero bits on the right make the full 20-bit base, and the offset is added to that base. The sum wraps within the 1 MB space, so every result lies between 00000H and FFFFFH. Each segment reaches at most FFFFH bytes above its base.

On each request the caller gives an access kind and an offset. It can also give a segment override. The block picks the segment from the access kind, applies the override where one is allowed, and registers the result. The address and the base it used come out one clock later, marked by a valid strobe. A write port loads the segment registers.

Top module: `segaddr_gen`

## Requirements
- R1: A synchronous reset (`rst` high) clears every segment register to 0000H except the code segment, which becomes FFFFH. While reset is high, `addr_valid` is low in the following cycle.
- R2: For a request accepted at one rising edge, `addr_valid` is high after the next rising edge. At that point `addr_out` equals segment × 16 + offset, taken from the segment and offset of that request.
- R3: A sum above FFFFFH wraps modulo 2^20. Segment FFFFH with offset 0010H gives 00000H.
- R4: With no override, the access kind `req_kind` selects the segment as follows: 0 (instruction fetch) uses code, 1 (stack access) uses stack, 2 (data access) uses data, and 3 (string destination) uses extra.
- R5: When `ovr_valid` is high and `ovr_sel` is 0 to 5, data accesses (kind 2) and stack accesses (kind 1) use the segment that `ovr_sel` names.
- R6: The override has no effect on instruction fetches (kind 0) or on string destinations (kind 3). An `ovr_sel` of 6 or 7 is also ignored, and the default segment is used.
- R7: A write with `wr_en` high loads `wr_data` into the register that `wr_sel` names: 0 code, 1 stack, 2 data, 3 extra, 4 first auxiliary, 5 second auxiliary. A request in the same cycle still sees the old value. Requests from the next cycle on see the new value.
- R8: A write with `wr_sel` of 6 or 7 changes no segment register.
- R9: Along with each valid address, `base_out` shows the base of the selected segment, which is the segment value × 16.
- R10: A cycle with `req_valid` low is followed by `addr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 3 | Register to write (0 to 5) |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | Access kind: fetch, stack, data, string destination |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 3 | Override segment (0 to 5) |
| offset | input | 16 | Offset within the segment |
| addr_valid | output | 1 | Registered result valid |
| addr_out | output | 20 | Physical address |
| base_out | output | 20 | Base of the segment used |

## Verification
The assertions assume that every request input is at a known level from the first clock edge. They also assume that reset is held for at least one edge before any check depends on register contents. The bench meets both conditions: it drives every input at time zero and holds reset for several cycles. After reset it changes inputs only on falling edges. The combinational checks on segment selection also assume that `req_kind` and the override inputs are driven even when `req_valid` is low. The bench never leaves them floating.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  parameter int SEG_W  = 16;
  parameter int OFF_W  = 16;
  parameter int SHIFT  = 4;
  localparam int ADDR_W  = SEG_W + SHIFT;
  localparam int NUM_SEG = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 3'd0,
    SEG_STACK = 3'd1,
    SEG_DATA  = 3'd2,
    SEG_EXTRA = 3'd3,
    SEG_AUX1  = 3'd4,
    SEG_AUX2  = 3'd5
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_kind_e;

  // Base of a segment: register value with SHIFT zero bits appended.
  function automatic logic [ADDR_W-1:0] seg_base(input logic [SEG_W-1:0] s);
    return {s, {SHIFT{1'b0}}};
  endfunction

  // Physical address, wrapping naturally at 2**ADDR_W.
  function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] s,
                                                  input logic [OFF_W-1:0] o);
    return seg_base(s) + ADDR_W'(o);
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import segaddr_pkg::*;
#(
  parameter int          W        = SEG_W,
  parameter int          N        = NUM_SEG,
  parameter int          SW       = SEL_W,
  parameter int          CODE_IDX = 0,
  parameter logic [W-1:0] CODE_RST = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] seg_flat
);
  // Named event: a write that lands on an existing register.
  logic wr_hit;
  assign wr_hit = wr_en && (wr_sel < SW'(N));

  for (genvar g = 0; g < N; g++) begin : g_seg
    localparam logic [W-1:0] RST_VAL = (g == CODE_IDX) ? CODE_RST : '0;
    always_ff @(posedge clk) begin
      if (rst)
        seg_flat[g*W +: W] <= RST_VAL;
      else if (wr_hit && wr_sel == SW'(g))
        seg_flat[g*W +: W] <= wr_data;
    end
  end

  // R1: after a reset edge the code segment holds its reset value
  a_r1_code_reset: assert property (@(posedge clk)
    rst |=> seg_flat[CODE_IDX*W +: W] == CODE_RST);

  // R1: every other segment is cleared after a reset edge
  a_r1_others_clear: assert property (@(posedge clk)
    rst |=> (seg_flat & ~({{(N*W-W){1'b0}}, {W{1'b1}}} << (CODE_IDX*W))) == '0);

  // R8: a write outside the register range leaves all registers unchanged
  a_r8_bad_sel_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit) |=> $stable(seg_flat));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import segaddr_pkg::*;
#(
  parameter int W  = SEG_W,
  parameter int N  = NUM_SEG,
  parameter int SW = SEL_W
) (
  input  acc_kind_e      kind,
  input  logic           ovr_valid,
  input  logic [SW-1:0]  ovr_sel,
  input  logic [N*W-1:0] seg_flat,
  output logic [SW-1:0]  sel_id,
  output logic [W-1:0]   sel_seg
);
  logic [SW-1:0] default_id;
  logic          ovr_legal;
  logic          ovr_allowed_kind;
  logic          ovr_applies;

  always_comb begin
    unique case (kind)
      ACC_FETCH:  default_id = SEG_CODE;
      ACC_STACK:  default_id = SEG_STACK;
      ACC_DATA:   default_id = SEG_DATA;
      default:    default_id = SEG_EXTRA;
    endcase
  end

  assign ovr_legal        = ovr_valid && (ovr_sel < SW'(N));
  assign ovr_allowed_kind = (kind == ACC_DATA) || (kind == ACC_STACK);
  assign ovr_applies      = ovr_legal && ovr_allowed_kind;
  assign sel_id           = ovr_applies ? ovr_sel : default_id;

  always_comb begin
    sel_seg = '0;
    for (int i = 0; i < N; i++)
      if (sel_id == SW'(i)) sel_seg = seg_flat[i*W +: W];
  end

  // R6: fetches and string destinations never take an override
  always_comb begin
    if (kind == ACC_FETCH)
      a_r6_fetch_keeps_code: assert (sel_id == SEG_CODE);
    if (kind == ACC_STRDST)
      a_r6_strdst_keeps_extra: assert (sel_id == SEG_EXTRA);
    // R5: the chosen id always names an existing register
    a_r5_sel_in_range: assert (sel_id < SW'(N));
  end
endmodule

// File: rtl/addr_stage.sv
module addr_stage
  import segaddr_pkg::*;
#(
  parameter int W  = SEG_W,
  parameter int OW = OFF_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [W-1:0]  seg,
  input  logic [OW-1:0] offset,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out,
  output logic [AW-1:0] base_out
);
  logic [AW-1:0] next_addr;
  logic [AW-1:0] next_base;
  assign next_addr = phys_addr(seg, offset);
  assign next_base = seg_base(seg);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
      base_out   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        addr_out <= next_addr;
        base_out <= next_base;
      end
    end
  end

  // R2: a request yields a valid result one clock later
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid);

  // R10: no request, no result
  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid);

  // R2: registered address and base stay consistent with the offset of the request
  a_r2_addr_matches_base: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_out == base_out + AW'($past(offset)));

  // R9: the reported base is segment aligned
  a_r9_base_aligned: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> base_out[AW-W-1:0] == '0);
endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
  import segaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              ovr_valid,
  input  logic [SEL_W-1:0]  ovr_sel,
  input  logic [OFF_W-1:0]  offset,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] base_out
);
  logic [NUM_SEG*SEG_W-1:0] seg_flat;
  logic [SEL_W-1:0]         sel_id;
  logic [SEG_W-1:0]         sel_seg;

  seg_regfile #(
    .W(SEG_W), .N(NUM_SEG), .SW(SEL_W),
    .CODE_IDX(int'(SEG_CODE)), .CODE_RST({SEG_W{1'b1}})
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .seg_flat(seg_flat)
  );

  seg_select #(.W(SEG_W), .N(NUM_SEG), .SW(SEL_W)) u_sel (
    .kind(acc_kind_e'(req_kind)), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .seg_flat(seg_flat), .sel_id(sel_id), .sel_seg(sel_seg)
  );

  addr_stage #(.W(SEG_W), .OW(OFF_W), .AW(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .seg(sel_seg),
    .offset(offset), .addr_valid(addr_valid), .addr_out(addr_out),
    .base_out(base_out)
  );
endmodule

// File: tb/segaddr_gen_tb_top.sv
`timescale 1ns/1ps
module segaddr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        ovr_valid = 1'b0;
  logic [2:0]  ovr_sel = '0;
  logic [15:0] offset = '0;
  logic        addr_valid;
  logic [19:0] addr_out;
  logic [19:0] base_out;

  always #2 clk = ~clk;  // 250 MHz

  segaddr_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .ovr_valid(ovr_valid),
    .ovr_sel(ovr_sel), .offset(offset), .addr_valid(addr_valid),
    .addr_out(addr_out), .base_out(base_out)
  );

  typedef struct {
    int          cyc;
    bit          vld;
    logic [19:0] addr;
    logic [19:0] base;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [15:0] model[6];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pick_seg(int kind, bit ov, int osel);
    if (kind == 0) return 0;
    if (kind == 3) return 3;
    if (ov && osel < 6) return osel;
    return (kind == 1) ? 1 : 2;
  endfunction

  // Driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(bit wr, int wsel, logic [15:0] wdat, bit rq, int kind,
                      bit ov, int osel, logic [15:0] off, string tag);
    exp_t e;
    int   s;
    @(negedge clk);
    wr_en = wr; wr_sel = 3'(wsel); wr_data = wdat;
    req_valid = rq; req_kind = 2'(kind); ovr_valid = ov; ovr_sel = 3'(osel);
    offset = off;
    s      = pick_seg(kind, ov, osel);
    e.cyc  = cyc;
    e.vld  = rq;
    e.base = 20'(int'(model[s]) * 16);
    e.addr = 20'((int'(model[s]) * 16 + int'(off)) % (1 << 20));
    e.tag  = tag;
    q.push_back(e);
    if (wr && wsel < 6) model[wsel] = wdat;
  endtask

  task automatic wr_only(int wsel, logic [15:0] wdat);
    step(1, wsel, wdat, 0, 0, 0, 0, 16'h0, "R10");
  endtask

  // Monitor: pops items whose result is due and compares
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].cyc + 1 == cyc) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (addr_valid !== e.vld) begin
          n_fail++;
          $display("FAIL %s valid: got %0b expected %0b", e.tag, addr_valid, e.vld);
        end else if (e.vld && (addr_out !== e.addr || base_out !== e.base)) begin
          n_fail++;
          $display("FAIL %s addr/base(R9): got %05h/%05h expected %05h/%05h",
                   e.tag, addr_out, base_out, e.addr, e.base);
        end
      end else if (addr_valid) begin
        n_chk++; n_fail++;
        $display("FAIL R10 unexpected valid: got 1 expected 0");
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 6; i++) model[i] = 16'h0000;
    model[0] = 16'hFFFF;
    // R1: outputs stay idle while reset is held, even with a request
    repeat (2) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    n_chk++;
    if (addr_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1 valid in reset: got %0b expected 0", addr_valid);
    end
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values seen through translation
    step(0, 0, 0, 1, 0, 0, 0, 16'h0000, "R1 code");
    step(0, 0, 0, 1, 1, 0, 0, 16'h1234, "R1 stack");
    step(0, 0, 0, 1, 3, 0, 0, 16'h0042, "R1 extra");
    // R7: same-cycle write is not seen, next cycle is
    step(1, 2, 16'h1000, 1, 2, 0, 0, 16'h0023, "R7 old");
    step(0, 0, 0, 1, 2, 0, 0, 16'h0023, "R2 10023");
    // R2: worked examples
    wr_only(2, 16'hAAF0);
    step(0, 0, 0, 1, 2, 0, 0, 16'h0134, "R2 AB034");
    wr_only(2, 16'h1200);
    step(0, 0, 0, 1, 2, 0, 0, 16'hFFF0, "R2 21FF0");
    // R3: wrap-around
    wr_only(1, 16'hFFFF);
    step(0, 0, 0, 1, 1, 0, 0, 16'h0010, "R3 wrap zero");
    step(0, 0, 0, 1, 1, 0, 0, 16'hFFFF, "R3 wrap high");
    // R4: defaults per access kind
    for (int i = 0; i < 6; i++) wr_only(i, 16'(16'h2000 + i * 16'h1000));
    step(0, 0, 0, 1, 0, 0, 0, 16'h0010, "R4 fetch");
    step(0, 0, 0, 1, 1, 0, 0, 16'h0010, "R4 stack");
    step(0, 0, 0, 1, 2, 0, 0, 16'h0010, "R4 data");
    step(0, 0, 0, 1, 3, 0, 0, 16'h0010, "R4 strdst");
    // R5: overrides on data and stack
    step(0, 0, 0, 1, 2, 1, 4, 16'h0100, "R5 data aux1");
    step(0, 0, 0, 1, 2, 1, 5, 16'h0200, "R5 data aux2");
    step(0, 0, 0, 1, 1, 1, 0, 16'h0300, "R5 stack code");
    step(0, 0, 0, 1, 2, 1, 3, 16'h0400, "R5 data extra");
    // R6: override ignored
    step(0, 0, 0, 1, 0, 1, 5, 16'h0500, "R6 fetch");
    step(0, 0, 0, 1, 3, 1, 1, 16'h0600, "R6 strdst");
    step(0, 0, 0, 1, 2, 1, 6, 16'h0700, "R6 sel6");
    step(0, 0, 0, 1, 1, 1, 7, 16'h0800, "R6 sel7");
    step(0, 0, 0, 1, 2, 0, 4, 16'h0900, "R6 no ovr_valid");
    // R8: out-of-range writes change nothing
    wr_only(6, 16'hDEAD);
    wr_only(7, 16'hBEEF);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 2, 1, i, 16'h0001, "R8 readback");
    // R10: idle cycles with busy inputs
    step(0, 0, 0, 0, 2, 1, 4, 16'hFFFF, "R10 idle");
    step(1, 3, 16'h1111, 0, 1, 0, 0, 16'h1234, "R10 idle write");
    step(0, 0, 0, 1, 3, 0, 0, 16'h0005, "R7 new extra");
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 16'h0, "R10 tail");
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++; $display("FAIL R2 pending results: got %0d expected 0", q.size());
    end
    summary();
  end
endmodule